// File: doc/BRIEF.md
# Addressing Mode Operand Fetch Unit

This block resolves a single source operand for a small processor. It receives the mode field, the register index and the short constant field of the current instruction, along with the contents of the named register, the next program counter and the operand size. From these it forms an effective address. Where the mode needs it, the block reads memory over a request/acknowledge port that tolerates any latency. It returns the operand value and the effective address. For the two pointer-stepping modes it also returns a one-cycle register write-back request.

A `start` pulse launches one resolution, and `done` pulses for one cycle when the results are valid. Memory indirection performs two dependent reads: the first read fetches a pointer and the second fetches the operand. Post-increment uses the register value as the address and writes back the stepped value. Pre-decrement steps the register first, uses the stepped value as the address and writes the same value back. The step is the operand size in bytes. PC-relative addressing shares the indexed mode code and is selected by the all-ones register index, which stands for the already-incremented program counter.

Top module: `opnd_fetch`

## Requirements
- R1: Mode code 0 (register) returns the register contents as the operand. It issues no memory request, and `done` rises in the cycle after `start`. `eff_addr` is 0.
- R2: Mode code 1 (absolute) reads memory once, at the constant field zero-extended to the data width, and returns the word read. `eff_addr` is that address.
- R3: Mode code 2 (immediate) returns the constant field sign-extended, with no memory request, and `done` rises in the cycle after `start`. When `is_dest` is 1, it instead pulses `illegal` together with `done` and returns operand 0.
- R4: Mode code 3 (register indirect) reads memory once, at the register contents, and returns the word read.
- R5: Mode code 4 (memory indirect) first reads at the zero-extended constant field. It then reads a second time, at the word returned by the first read, and returns the second word. `eff_addr` is the pointer.
- R6: Mode code 5 with a register index other than all-ones (indexed) reads at the register contents plus the sign-extended constant, modulo 2^DW. It requests no write-back.
- R7: Mode code 5 with the all-ones register index (relative) reads at `pc_next` plus the sign-extended constant, modulo 2^DW. The offset may be negative.
- R8: Mode code 6 (post-increment) reads at the register contents. It requests a write-back of the register contents plus the step to the same register index.
- R9: Mode code 7 (pre-decrement) reads at the register contents minus the step. It writes that same value back to the same register index.
- R10: The step is set by `size_sel`: 00 gives 1, 01 gives 2, and 1x gives 4 bytes.
- R11: `done` is high for exactly one cycle per resolution. `wb_en` is high only in that cycle, and only for mode codes 6 and 7.
- R12: `mem_req` and `mem_addr` stay unchanged until `mem_ack`. Each read adds (wait cycles + 1) to the latency, so `done` comes 1 + the sum of the read durations after `start`.
- R13: A `start` seen while a resolution is in progress is ignored, and the running resolution completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one resolution (sampled when idle) |
| is_dest | input | 1 | Operand is requested as a destination |
| mode | input | 3 | Addressing mode code |
| reg_idx | input | RIDX_W | Register index from the instruction |
| const_fld | input | CONST_W | Constant field from the instruction |
| size_sel | input | 2 | Operand size: 00=1, 01=2, 1x=4 bytes |
| pc_next | input | DW | Program counter already past the instruction |
| rf_raddr | output | RIDX_W | Register file read address |
| rf_rdata | input | DW | Register file read data for `rf_raddr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_ack | input | 1 | Read accepted and data valid this cycle |
| mem_rdata | input | DW | Memory read data |
| done | output | 1 | One-cycle result-valid pulse |
| illegal | output | 1 | Immediate requested as destination, pulses with `done` |
| operand | output | DW | Resolved operand |
| eff_addr | output | DW | Effective address of the operand |
| wb_en | output | 1 | Register write-back request, pulses with `done` |
| wb_idx | output | RIDX_W | Register to write back |
| wb_data | output | DW | Stepped pointer value |

## Verification
The hardest case to reach from the ports is memory indirection combined with a slow memory. Here the second read's address exists only as data returned by the first read, and the request must stay stable for several unacknowledged cycles. The bench's memory returns an address-dependent word that is chosen so that pointers land on distinct addresses. Its acknowledge delay changes from run to run, and the bench records the addresses of the last two accepted reads. Post-increment and pre-decrement are swept over registers whose values sit near zero and near all-ones, so that stepping wraps. A busy-window `start` is injected halfway through a slow read.

// File: rtl/opf_pkg.sv
// Package: shared types of the operand fetch unit.
// Assumes a 3-bit mode field; code 5 doubles as PC-relative when the
// register index is all ones.
package opf_pkg;

    typedef enum logic [2:0] {
        AM_REG  = 3'd0,
        AM_ABS  = 3'd1,
        AM_IMM  = 3'd2,
        AM_RIND = 3'd3,
        AM_MIND = 3'd4,
        AM_IDX  = 3'd5,
        AM_PINC = 3'd6,
        AM_PDEC = 3'd7
    } amode_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD1  = 2'd1,
        S_RD2  = 2'd2,
        S_FIN  = 2'd3
    } seq_st_t;

endpackage

// File: rtl/opf_addr_gen.sv
// Module: opf_addr_gen
// Purely combinational address arithmetic. It forms the effective address,
// the write-back value, the immediate value and the memory-use class for
// the current instruction fields. It assumes DW > CONST_W and that the
// all-ones register index in indexed mode denotes the program counter.
module opf_addr_gen
    import opf_pkg::*;
#(
    parameter int DW      = 16,
    parameter int RIDX_W  = 3,
    parameter int CONST_W = 8
) (
    input  logic [2:0]         mode,
    input  logic [RIDX_W-1:0]  reg_idx,
    input  logic [CONST_W-1:0] cst,
    input  logic [1:0]         size_sel,
    input  logic [DW-1:0]      reg_val,
    input  logic [DW-1:0]      pc_next,
    output logic [DW-1:0]      ea,
    output logic [DW-1:0]      wb_val,
    output logic [DW-1:0]      imm_val,
    output logic               needs_mem,
    output logic               two_reads,
    output logic               has_wb
);
    localparam int EXT_W = DW - CONST_W;

    logic [DW-1:0] sext;
    logic [DW-1:0] zext;
    logic [DW-1:0] step;
    logic [DW-1:0] idx_base;
    amode_t        m;

    // Extend the constant field both ways.
    always_comb begin
        sext = {{EXT_W{cst[CONST_W-1]}}, cst};
        zext = {{EXT_W{1'b0}}, cst};
    end

    // Pointer step from the operand size.
    always_comb begin
        step = '0;
        case (size_sel)
            2'b00:   step[0] = 1'b1;
            2'b01:   step[1] = 1'b1;
            default: step[2] = 1'b1;
        endcase
    end

    // Base for indexed mode: the PC stands in for the all-ones index.
    always_comb begin
        idx_base = (reg_idx == {RIDX_W{1'b1}}) ? pc_next : reg_val;
    end

    // Mode decode into the address, write-back value and sequencing class.
    always_comb begin
        m         = amode_t'(mode);
        ea        = '0;
        wb_val    = '0;
        needs_mem = 1'b1;
        two_reads = 1'b0;
        has_wb    = 1'b0;
        imm_val   = sext;
        case (m)
            AM_REG:  needs_mem = 1'b0;
            AM_IMM:  needs_mem = 1'b0;
            AM_ABS:  ea = zext;
            AM_RIND: ea = reg_val;
            AM_MIND: begin
                ea        = zext;
                two_reads = 1'b1;
            end
            AM_IDX:  ea = idx_base + sext;
            AM_PINC: begin
                ea     = reg_val;
                wb_val = reg_val + step;
                has_wb = 1'b1;
            end
            AM_PDEC: begin
                ea     = reg_val - step;
                wb_val = reg_val - step;
                has_wb = 1'b1;
            end
            default: needs_mem = 1'b0;
        endcase
    end

endmodule

// File: rtl/opf_seq.sv
// Module: opf_seq
// Sequencer of the operand fetch unit. It latches the decoded request on
// start, performs zero, one or two memory reads, and pulses done with the
// results and the optional write-back. It assumes the memory holds data
// valid in the cycle it raises ack, and that start is ignored while busy.
module opf_seq
    import opf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_dest,
    input  logic [2:0]        mode,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [DW-1:0]     reg_val,
    input  logic [DW-1:0]     ea,
    input  logic [DW-1:0]     wb_val,
    input  logic [DW-1:0]     imm_val,
    input  logic              needs_mem,
    input  logic              two_reads,
    input  logic              has_wb,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic [DW-1:0]     operand,
    output logic [DW-1:0]     eff_addr,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [DW-1:0]     wb_data
);
    seq_st_t           st;
    logic [DW-1:0]     addr_q;
    logic [DW-1:0]     op_q;
    logic [DW-1:0]     eff_q;
    logic [DW-1:0]     wbv_q;
    logic [RIDX_W-1:0] idx_q;
    logic              two_q;
    logic              wb_q;
    logic              ill_q;

    // State, latched request and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            addr_q <= '0;
            op_q   <= '0;
            eff_q  <= '0;
            wbv_q  <= '0;
            idx_q  <= '0;
            two_q  <= 1'b0;
            wb_q   <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        idx_q <= reg_idx;
                        wbv_q <= wb_val;
                        wb_q  <= has_wb;
                        two_q <= two_reads;
                        ill_q <= 1'b0;
                        if (needs_mem) begin
                            addr_q <= ea;
                            eff_q  <= ea;
                            st     <= S_RD1;
                        end else begin
                            eff_q <= '0;
                            if (amode_t'(mode) == AM_IMM) begin
                                op_q  <= is_dest ? '0 : imm_val;
                                ill_q <= is_dest;
                            end else begin
                                op_q <= reg_val;
                            end
                            st <= S_FIN;
                        end
                    end
                end
                S_RD1: begin
                    if (mem_ack) begin
                        if (two_q) begin
                            addr_q <= mem_rdata;
                            eff_q  <= mem_rdata;
                            st     <= S_RD2;
                        end else begin
                            op_q <= mem_rdata;
                            st   <= S_FIN;
                        end
                    end
                end
                S_RD2: begin
                    if (mem_ack) begin
                        op_q <= mem_rdata;
                        st   <= S_FIN;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Output drive from state and latched values.
    always_comb begin
        mem_req  = (st == S_RD1) || (st == S_RD2);
        mem_addr = addr_q;
        done     = (st == S_FIN);
        illegal  = done && ill_q;
        wb_en    = done && wb_q;
        wb_idx   = idx_q;
        wb_data  = wbv_q;
        operand  = op_q;
        eff_addr = eff_q;
    end

    // R11: done lasts one cycle only.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: write-back appears only with done.
    a_r11_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R12: an unanswered request holds its address.
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3: the illegal flag pulses only with done.
    a_r3_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    // R13: start during a read never returns the sequencer to idle.
    a_r13_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && start) |=> !done && mem_req);

    // R1: an idle sequencer issues no request.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !mem_req && !done);

endmodule

// File: rtl/opnd_fetch.sv
// Module: opnd_fetch (top)
// Operand fetch unit: combines the address arithmetic with the read
// sequencer. It assumes the register file read port returns rf_rdata for
// rf_raddr in the same cycle, and that a memory read is complete in the
// cycle mem_ack is high.
module opnd_fetch #(
    parameter int DW      = 16,
    parameter int RIDX_W  = 3,
    parameter int CONST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_dest,
    input  logic [2:0]         mode,
    input  logic [RIDX_W-1:0]  reg_idx,
    input  logic [CONST_W-1:0] const_fld,
    input  logic [1:0]         size_sel,
    input  logic [DW-1:0]      pc_next,
    output logic [RIDX_W-1:0]  rf_raddr,
    input  logic [DW-1:0]      rf_rdata,
    output logic               mem_req,
    output logic [DW-1:0]      mem_addr,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output logic               done,
    output logic               illegal,
    output logic [DW-1:0]      operand,
    output logic [DW-1:0]      eff_addr,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic [DW-1:0]      wb_data
);
    logic [DW-1:0] ea;
    logic [DW-1:0] wb_val;
    logic [DW-1:0] imm_val;
    logic          needs_mem;
    logic          two_reads;
    logic          has_wb;

    // Register file is addressed straight from the instruction field.
    always_comb rf_raddr = reg_idx;

    opf_addr_gen #(.DW(DW), .RIDX_W(RIDX_W), .CONST_W(CONST_W)) u_agen (
        .mode      (mode),
        .reg_idx   (reg_idx),
        .cst       (const_fld),
        .size_sel  (size_sel),
        .reg_val   (rf_rdata),
        .pc_next   (pc_next),
        .ea        (ea),
        .wb_val    (wb_val),
        .imm_val   (imm_val),
        .needs_mem (needs_mem),
        .two_reads (two_reads),
        .has_wb    (has_wb)
    );

    opf_seq #(.DW(DW), .RIDX_W(RIDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_dest   (is_dest),
        .mode      (mode),
        .reg_idx   (reg_idx),
        .reg_val   (rf_rdata),
        .ea        (ea),
        .wb_val    (wb_val),
        .imm_val   (imm_val),
        .needs_mem (needs_mem),
        .two_reads (two_reads),
        .has_wb    (has_wb),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done),
        .illegal   (illegal),
        .operand   (operand),
        .eff_addr  (eff_addr),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data)
    );

endmodule

// File: tb/opnd_fetch_bench.sv
// Bench: sweeps modes, registers, constants, sizes, destination flag and
// memory latency; expected values are computed arithmetically.
module opnd_fetch_bench;
    localparam int DW = 16;
    localparam int RW = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_dest = 1'b0;
    logic [2:0]    mode = '0;
    logic [RW-1:0] reg_idx = '0;
    logic [CW-1:0] const_fld = '0;
    logic [1:0]    size_sel = '0;
    logic [DW-1:0] pc_next = 16'h4000;
    logic [RW-1:0] rf_raddr;
    logic [DW-1:0] rf_rdata;
    logic          mem_req;
    logic [DW-1:0] mem_addr;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;
    logic          done, illegal, wb_en;
    logic [DW-1:0] operand, eff_addr, wb_data;
    logic [RW-1:0] wb_idx;

    logic [DW-1:0] rf [8];
    logic [3:0]    lat = '0;
    logic [3:0]    wcnt = '0;
    int            rd_n = 0;
    logic [DW-1:0] rd_last = '0, rd_prev = '0;
    int            tests = 0, fails = 0;

    always #2 clk = ~clk;

    opnd_fetch #(.DW(DW), .RIDX_W(RW), .CONST_W(CW)) u_opnd_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .is_dest(is_dest),
        .mode(mode), .reg_idx(reg_idx), .const_fld(const_fld),
        .size_sel(size_sel), .pc_next(pc_next), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .illegal(illegal), .operand(operand), .eff_addr(eff_addr),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [DW-1:0] fmem(input logic [DW-1:0] a);
        return (a ^ 16'h5A3C) + 16'd7;
    endfunction

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = fmem(mem_addr);
    assign mem_ack   = mem_req && (wcnt >= lat);

    // Memory responder: latency counter and read log.
    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            wcnt    <= '0;
            rd_n    <= rd_n + 1;
            rd_prev <= rd_last;
            rd_last <= mem_addr;
        end else if (mem_req) begin
            wcnt <= wcnt + 4'd1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] stepv(input logic [1:0] s);
        return (s == 2'b00) ? 16'd1 : (s == 2'b01) ? 16'd2 : 16'd4;
    endfunction

    // One resolution; poke injects a busy-window start (R13).
    task automatic run(input int m, input int idx, input logic [CW-1:0] c,
                       input logic [1:0] sz, input bit dst, input int l,
                       input bit poke);
        logic [DW-1:0] rv, sx, zx, e_op, e_ea, e_wb, e_a1;
        int e_nrd, cyc, base_n;
        bit e_wb_en, e_ill;
        string tg;
        rv = rf[idx];
        sx = {{(DW-CW){c[CW-1]}}, c};
        zx = {{(DW-CW){1'b0}}, c};
        e_op = '0; e_ea = '0; e_wb = '0; e_a1 = '0;
        e_nrd = 0; e_wb_en = 0; e_ill = 0;
        case (m)
            0: begin e_op = rv; tg = "R1"; end
            1: begin e_ea = zx; e_op = fmem(zx); e_nrd = 1; tg = "R2"; end
            2: begin e_ill = dst; e_op = dst ? '0 : sx; tg = "R3"; end
            3: begin e_ea = rv; e_op = fmem(rv); e_nrd = 1; tg = "R4"; end
            4: begin e_a1 = zx; e_ea = fmem(zx); e_op = fmem(e_ea);
                     e_nrd = 2; tg = "R5"; end
            5: begin
                if (idx == 7) begin e_ea = pc_next + sx; tg = "R7"; end
                else begin e_ea = rv + sx; tg = "R6"; end
                e_op = fmem(e_ea); e_nrd = 1;
            end
            6: begin e_ea = rv; e_wb = rv + stepv(sz); e_wb_en = 1;
                     e_op = fmem(e_ea); e_nrd = 1; tg = "R8 R10"; end
            default: begin e_ea = rv - stepv(sz); e_wb = e_ea; e_wb_en = 1;
                     e_op = fmem(e_ea); e_nrd = 1; tg = "R9 R10"; end
        endcase
        @(negedge clk);
        lat = 4'(l);
        base_n = rd_n;
        mode = 3'(m); reg_idx = RW'(idx); const_fld = c; size_sel = sz;
        is_dest = dst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            if (poke && cyc == 1) begin
                start = 1'b1; mode = 3'd0; reg_idx = 3'd5;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, {tg, " done"}, 32'(done), 1);
        chk(operand == e_op, {tg, " operand"}, 32'(operand), 32'(e_op));
        chk(eff_addr == e_ea, {tg, " eff_addr"}, 32'(eff_addr), 32'(e_ea));
        chk(illegal == e_ill, "R3 illegal", 32'(illegal), 32'(e_ill));
        chk(wb_en == e_wb_en, "R11 wb_en", 32'(wb_en), 32'(e_wb_en));
        if (e_wb_en) begin
            chk(wb_data == e_wb, {tg, " wb_data"}, 32'(wb_data), 32'(e_wb));
            chk(wb_idx == RW'(idx), {tg, " wb_idx"}, 32'(wb_idx), 32'(idx));
        end
        chk(rd_n - base_n == e_nrd, {tg, " read count"}, 32'(rd_n - base_n),
            32'(e_nrd));
        if (e_nrd == 2)
            chk(rd_prev == e_a1 && rd_last == e_ea, "R5 read addresses",
                32'(rd_prev), 32'(e_a1));
        else if (e_nrd == 1)
            chk(rd_last == e_ea, {tg, " read address"}, 32'(rd_last), 32'(e_ea));
        chk(cyc == 1 + e_nrd * (l + 1), "R12 latency", 32'(cyc),
            32'(1 + e_nrd * (l + 1)));
        @(negedge clk);
        chk(!done && !wb_en, "R11 single pulse", 32'(done), 0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [CW-1:0] cs [6];
        cs[0] = 8'h00; cs[1] = 8'h01; cs[2] = 8'h7F;
        cs[3] = 8'h80; cs[4] = 8'hFF; cs[5] = 8'h35;
        rf[0] = 16'h0001; rf[1] = 16'hFFFE;
        for (int i = 2; i < 8; i++) rf[i] = 16'(16'h1000 * i + 16'h0123 * i);
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !wb_en && !illegal && operand == 0,
            "R1 reset state", 32'(done), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++)
            for (int idx = 0; idx < 8; idx++)
                for (int ci = 0; ci < 6; ci++)
                    for (int sz = 0; sz < 4; sz++) begin
                        pc_next = (ci == 3) ? 16'h0010 : 16'h4000;
                        run(m, idx, cs[ci], 2'(sz), (idx % 2) == 1,
                            (m + idx + ci + sz) % 4, 1'b0);
                    end
        // R13: start during a slow indirect read is ignored.
        run(3, 2, 8'h00, 2'b00, 1'b0, 3, 1'b1);
        run(4, 4, 8'h22, 2'b00, 1'b0, 3, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule